// File: doc/BRIEF.md
# Eight-channel output compare port controller

This block sits between a bank of eight timer channels and an 8-bit timer port. Each channel is configured either as input capture or as output compare. A channel in output compare mode compares a 16-bit free-running count, supplied from outside, against its own compare value. On a match it applies its programmed pin action, which is none, toggle, clear or set, to an internal timer output bit. Software can also fire that action through a force register. A forced action behaves like a match but leaves the channel's flag alone. Channel 7 is special: when it fires, it also loads a pattern from its data register into every timer output bit that its mask register selects. In the same cycle that load wins over a channel's own action.

Each pin is in one of three modes. **Input** is the undriven mode. In **general output** the pin drives the port latch. In **timer-owned** it drives the timer output bit. A pin enters timer-owned when its channel is selected for output compare and either has an action other than none or is selected by the channel 7 mask. It leaves timer-owned when any of those conditions is removed by a register write. It then falls back to general output if its direction bit is 1, or to input if it is 0. A write to the direction register moves a pin between input and general output, but never out of timer-owned. Writes to the port latch are always stored, and a pin that returns from timer-owned drives the last value written. Software uses a single-cycle register bus with combinational read data. The per-channel match flags are outputs for an interrupt controller outside this block.

Top module: `oc_port_ctrl`

## Requirements
- R1: After reset, all registers, compare values, actions and timer output bits are zero, so `pin_oe`, `pin_out` and `cmp_flag` read 0x00.
- R2: The select register at address 0x00 can be written and read at any time. Bit n = 1 makes channel n output compare and bit n = 0 makes it input capture.
- R3: When channel n is output compare and `tmr_count` equals its compare value at a clock edge, its action is applied to timer output bit n after that edge, and `cmp_flag[n]` is 1 for the following cycle. Action codes: 00 none, 01 toggle, 10 clear, 11 set.
- R4: Writing 1 to bit n of the force register (address 0x01) applies channel n's action after that edge, exactly as a match would, but `cmp_flag[n]` stays 0.
- R5: The force register always reads 0x00.
- R6: When channel 7 fires by match or by force, each timer output bit whose channel 7 mask bit (address 0x02) is 1 takes the matching bit of the channel 7 data register (address 0x03). Bits whose mask bit is 0 are untouched by that load.
- R7: If channel 7's masked load and a channel's own action hit the same bit in the same cycle, the masked load value wins.
- R8: A timer-owned pin has `pin_oe` = 1 and drives its timer output bit, whatever its direction bit says. The direction register keeps the value software wrote.
- R9: A pin that is not timer-owned has `pin_oe` equal to its direction bit (address 0x05) and drives the port latch (address 0x04). A read of address 0x04 returns `pin_out` for bits with `pin_oe` = 1 and `pin_in` for the others.
- R10: A port latch write to a timer-owned pin does not change that pin. The pin drives the written value once it leaves timer-owned.
- R11: A channel in input capture mode ignores matches and force bits, and its flag stays 0.
- R12: Mask, data and direction registers read back as written. The action for channel n sits at bits 2(n mod 4)+1:2(n mod 4) of address 0x06 (channels 0 to 3) or 0x07 (channels 4 to 7). The compare value of channel n has its low byte at 0x10+2n and its high byte at 0x11+2n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Register write strobe, one access per cycle |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| tmr_count | input | 16 | Free-running count compared by the channels |
| pin_in | input | 8 | Levels sensed on the port pins |
| pin_out | output | 8 | Levels driven onto the port pins |
| pin_oe | output | 8 | Per-pin output enable |
| cmp_flag | output | 8 | Per-channel compare match flag |

## Verification
The assertions assume that at most one register access happens per clock, so the pin modes cannot change in the same cycle as a port latch write. They also assume that the count, address and write data are steady around each edge. The stimulus meets both assumptions by changing every input shortly after a rising edge and by issuing one write per cycle. The count advances by one per cycle and jumps only between edges to land on a chosen compare value. Forces, matches and the channel 7 load are aimed at bits whose action and mask differ. This makes the priority rule and the flag-free force visible on the pins.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
    localparam int NUM_CH       = 8;
    localparam int CNT_W        = 16;
    localparam int ADDR_W       = 5;
    localparam int ACT_W        = 2;
    localparam int ACTS_PER_REG = NUM_CH / 2;
    localparam int CH_IDX_W     = $clog2(NUM_CH);

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_action_e;

    typedef enum logic [1:0] {
        PIN_INPUT    = 2'd0,
        PIN_GPIO_OUT = 2'd1,
        PIN_TIMER    = 2'd2
    } pin_mode_e;

    localparam logic [ADDR_W-1:0] ADR_SELECT = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_FORCE  = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_MASK7  = 5'h02;
    localparam logic [ADDR_W-1:0] ADR_DATA7  = 5'h03;
    localparam logic [ADDR_W-1:0] ADR_PORT   = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_DIR    = 5'h05;
    localparam logic [ADDR_W-1:0] ADR_ACT_LO = 5'h06;
    localparam logic [ADDR_W-1:0] ADR_ACT_HI = 5'h07;
endpackage

// File: rtl/oc_channel.sv
`timescale 1ns/1ps
module oc_channel
    import oc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          oc_en_i,
    input  logic          force_i,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] cmp_i,
    input  oc_action_e    act_i,
    input  logic          cur_i,
    output logic          event_o,
    output logic          next_o,
    output logic          flag_o
);
    logic match;
    logic flag_q;

    assign match   = (count_i == cmp_i);
    assign event_o = oc_en_i & (match | force_i);

    // value the timer bit takes if this channel fires
    always_comb begin
        unique case (act_i)
            ACT_NONE:   next_o = cur_i;
            ACT_TOGGLE: next_o = ~cur_i;
            ACT_CLEAR:  next_o = 1'b0;
            ACT_SET:    next_o = 1'b1;
        endcase
    end

    // only a real match raises the flag; a force never does
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= oc_en_i & match;
        end
    end

    assign flag_o = flag_q;

    // R4
    force_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (force_i && (count_i != cmp_i)) |=> !flag_o);

    // R11
    ic_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !oc_en_i |=> !flag_o);
endmodule

// File: rtl/oc_pin_mux.sv
`timescale 1ns/1ps
module oc_pin_mux
    import oc_pkg::*;
#(
    parameter int W = NUM_CH
) (
    input  logic [W-1:0] oc_sel_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] act_nz_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] port_i,
    input  logic [W-1:0] timer_i,
    output logic [W-1:0] pin_out_o,
    output logic [W-1:0] pin_oe_o,
    output logic [W-1:0] own_o
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        pin_mode_e mode;
        logic      out_b;
        logic      oe_b;
        logic      own_b;

        // mode of this pin from the current configuration
        always_comb begin
            if (oc_sel_i[n] && (act_nz_i[n] || mask_i[n])) begin
                mode = PIN_TIMER;
            end else if (dir_i[n]) begin
                mode = PIN_GPIO_OUT;
            end else begin
                mode = PIN_INPUT;
            end
        end

        // drive for each mode
        always_comb begin
            unique case (mode)
                PIN_TIMER: begin
                    out_b = timer_i[n];
                    oe_b  = 1'b1;
                    own_b = 1'b1;
                end
                PIN_GPIO_OUT: begin
                    out_b = port_i[n];
                    oe_b  = 1'b1;
                    own_b = 1'b0;
                end
                default: begin
                    out_b = port_i[n];
                    oe_b  = 1'b0;
                    own_b = 1'b0;
                end
            endcase
        end

        assign pin_out_o[n] = out_b;
        assign pin_oe_o[n]  = oe_b;
        assign own_o[n]     = own_b;
    end
endmodule

// File: rtl/oc_port_ctrl.sv
`timescale 1ns/1ps
module oc_port_ctrl
    import oc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  bus_addr,
    input  logic        bus_we,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [15:0] tmr_count,
    input  logic [7:0]  pin_in,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_oe,
    output logic [7:0]  cmp_flag
);
    localparam int HALF_W = CNT_W / 2;
    localparam int LAST   = NUM_CH - 1;

    logic [NUM_CH-1:0] sel_q, mask7_q, data7_q, port_q, dir_q, oc_q, oc_d;
    logic [NUM_CH-1:0] force_v, ev, nxt, act_nz, own;
    oc_action_e        act_q [NUM_CH];
    logic [CNT_W-1:0]  cmp_q [NUM_CH];
    logic [CH_IDX_W-1:0] cmp_idx;
    logic              cmp_hi;
    logic              cmp_space;

    assign cmp_space = bus_addr[ADDR_W-1];
    assign cmp_idx   = bus_addr[CH_IDX_W:1];
    assign cmp_hi    = bus_addr[0];
    assign force_v   = (bus_we && bus_addr == ADR_FORCE) ? bus_wdata : '0;

    // register file and timer output bits
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            mask7_q <= '0;
            data7_q <= '0;
            port_q  <= '0;
            dir_q   <= '0;
            oc_q    <= '0;
            for (int n = 0; n < NUM_CH; n++) begin
                act_q[n] <= ACT_NONE;
                cmp_q[n] <= '0;
            end
        end else begin
            oc_q <= oc_d;
            if (bus_we) begin
                if (cmp_space) begin
                    if (cmp_hi) begin
                        cmp_q[cmp_idx][CNT_W-1:HALF_W] <= bus_wdata;
                    end else begin
                        cmp_q[cmp_idx][HALF_W-1:0] <= bus_wdata;
                    end
                end else begin
                    case (bus_addr)
                        ADR_SELECT: sel_q   <= bus_wdata;
                        ADR_MASK7:  mask7_q <= bus_wdata;
                        ADR_DATA7:  data7_q <= bus_wdata;
                        ADR_PORT:   port_q  <= bus_wdata;
                        ADR_DIR:    dir_q   <= bus_wdata;
                        ADR_ACT_LO: begin
                            for (int k = 0; k < ACTS_PER_REG; k++) begin
                                act_q[k] <= oc_action_e'(bus_wdata[ACT_W*k +: ACT_W]);
                            end
                        end
                        ADR_ACT_HI: begin
                            for (int k = 0; k < ACTS_PER_REG; k++) begin
                                act_q[k+ACTS_PER_REG] <= oc_action_e'(bus_wdata[ACT_W*k +: ACT_W]);
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        oc_channel #(.CW(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .oc_en_i (sel_q[n]),
            .force_i (force_v[n]),
            .count_i (tmr_count),
            .cmp_i   (cmp_q[n]),
            .act_i   (act_q[n]),
            .cur_i   (oc_q[n]),
            .event_o (ev[n]),
            .next_o  (nxt[n]),
            .flag_o  (cmp_flag[n])
        );
        assign act_nz[n] = (act_q[n] != ACT_NONE);
    end

    // own actions first, channel 7 pattern on top
    always_comb begin
        oc_d = oc_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if (ev[n]) begin
                oc_d[n] = nxt[n];
            end
        end
        if (ev[LAST]) begin
            oc_d = (oc_d & ~mask7_q) | (data7_q & mask7_q);
        end
    end

    oc_pin_mux #(.W(NUM_CH)) u_mux (
        .oc_sel_i  (sel_q),
        .mask_i    (mask7_q),
        .act_nz_i  (act_nz),
        .dir_i     (dir_q),
        .port_i    (port_q),
        .timer_i   (oc_q),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe),
        .own_o     (own)
    );

    // read path
    always_comb begin
        bus_rdata = '0;
        if (cmp_space) begin
            bus_rdata = cmp_hi ? cmp_q[cmp_idx][CNT_W-1:HALF_W] : cmp_q[cmp_idx][HALF_W-1:0];
        end else begin
            case (bus_addr)
                ADR_SELECT: bus_rdata = sel_q;
                ADR_MASK7:  bus_rdata = mask7_q;
                ADR_DATA7:  bus_rdata = data7_q;
                ADR_PORT:   bus_rdata = (pin_out & pin_oe) | (pin_in & ~pin_oe);
                ADR_DIR:    bus_rdata = dir_q;
                ADR_ACT_LO: begin
                    for (int k = 0; k < ACTS_PER_REG; k++) begin
                        bus_rdata[ACT_W*k +: ACT_W] = act_q[k];
                    end
                end
                ADR_ACT_HI: begin
                    for (int k = 0; k < ACTS_PER_REG; k++) begin
                        bus_rdata[ACT_W*k +: ACT_W] = act_q[k+ACTS_PER_REG];
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R5
    force_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_FORCE) |-> (bus_rdata == '0));

    // R6 R7
    ch7_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        ev[LAST] |=> (((oc_q ^ $past(data7_q)) & $past(mask7_q)) == '0));

    // R8
    timer_drives_chk: assert property (@(posedge clk) disable iff (rst)
        ((sel_q & mask7_q & ~pin_oe) == '0));

    // R10
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_PORT) |=> (((pin_out ^ $past(bus_wdata)) & ~own) == '0));
endmodule

// File: tb/test_oc_port_ctrl.sv
`timescale 1ns/1ps
module test_oc_port_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        we_r = 1'b0;
    logic [7:0]  wdata = '0;
    logic [15:0] cnt = 16'h8000;
    logic [7:0]  pin_in = 8'h33;
    logic [7:0]  rdata, pout, poe, flag;
    int          checks = 0;
    int          errors = 0;
    string       phase = "R1";
    logic        done = 1'b0;

    oc_port_ctrl i_oc_port_ctrl (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we_r), .bus_wdata(wdata),
        .bus_rdata(rdata), .tmr_count(cnt), .pin_in(pin_in), .pin_out(pout),
        .pin_oe(poe), .cmp_flag(flag)
    );

    always #10 clk = ~clk;

    // behavioural reference state
    logic [7:0] m_sel, m_mask, m_data, m_port, m_dir, m_oc, m_flag;
    int         m_act [8];
    int         m_cmp [8];

    task automatic model_step();
        logic [7:0] nx, ev, fl;
        bit hit, frc;
        int c;
        nx = m_oc; ev = '0; fl = '0;
        for (int n = 0; n < 8; n++) begin
            hit   = m_sel[n] && (int'(cnt) == m_cmp[n]);
            frc   = we_r && (addr == 5'h01) && wdata[n];
            fl[n] = hit;
            ev[n] = m_sel[n] && (hit || frc);
            if (ev[n]) begin
                if (m_act[n] == 1) nx[n] = ~nx[n];
                else if (m_act[n] == 2) nx[n] = 1'b0;
                else if (m_act[n] == 3) nx[n] = 1'b1;
            end
        end
        if (ev[7]) begin
            for (int n = 0; n < 8; n++) if (m_mask[n]) nx[n] = m_data[n];
        end
        if (we_r) begin
            if (addr[4]) begin
                c = int'(addr[3:1]);
                if (addr[0]) m_cmp[c] = (m_cmp[c] & 255) | (int'(wdata) << 8);
                else m_cmp[c] = (m_cmp[c] & 16'hFF00) | int'(wdata);
            end else begin
                case (addr)
                    5'h00: m_sel  = wdata;
                    5'h02: m_mask = wdata;
                    5'h03: m_data = wdata;
                    5'h04: m_port = wdata;
                    5'h05: m_dir  = wdata;
                    5'h06: for (int k = 0; k < 4; k++) m_act[k] = int'(wdata[2*k +: 2]);
                    5'h07: for (int k = 0; k < 4; k++) m_act[k+4] = int'(wdata[2*k +: 2]);
                    default: ;
                endcase
            end
        end
        m_oc = nx;
        m_flag = fl;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sel = '0; m_mask = '0; m_data = '0; m_port = '0; m_dir = '0;
            m_oc = '0; m_flag = '0;
            for (int n = 0; n < 8; n++) begin
                m_act[n] = 0;
                m_cmp[n] = 0;
            end
        end else begin
            model_step();
        end
    end

    function automatic logic [7:0] m_own();
        logic [7:0] o;
        for (int n = 0; n < 8; n++) o[n] = m_sel[n] && (m_act[n] != 0 || m_mask[n]);
        return o;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] o;
        o = m_own();
        return (o & m_oc) | (~o & m_port);
    endfunction

    function automatic logic [7:0] exp_oe();
        return m_own() | m_dir;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [7:0] r, o;
        int c;
        r = '0;
        if (addr[4]) begin
            c = int'(addr[3:1]);
            r = addr[0] ? 8'(m_cmp[c] >> 8) : 8'(m_cmp[c]);
        end else begin
            case (addr)
                5'h00: r = m_sel;
                5'h02: r = m_mask;
                5'h03: r = m_data;
                5'h04: begin o = exp_oe(); r = (exp_out() & o) | (pin_in & ~o); end
                5'h05: r = m_dir;
                5'h06: for (int k = 0; k < 4; k++) r[2*k +: 2] = 2'(m_act[k]);
                5'h07: for (int k = 0; k < 4; k++) r[2*k +: 2] = 2'(m_act[k+4]);
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(phase, "model pin_out", pout, exp_out());
            check(phase, "model pin_oe", poe, exp_oe());
            check(phase, "model cmp_flag", flag, m_flag);
            check(phase, "model rdata", rdata, exp_rd());
        end
    end

    task automatic step(input logic [4:0] a, input logic w, input logic [7:0] d);
        @(posedge clk);
        #2;
        addr = a; we_r = w; wdata = d; cnt = cnt + 16'd1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        step(a, 1'b1, d);
    endtask

    task automatic idle();
        step(5'h00, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp);
        step(a, 1'b0, 8'h00);
        @(negedge clk);
        check(phase, "rdata", rdata, exp);
    endtask

    task automatic pins(input logic [7:0] eo, input logic [7:0] ee, input logic [7:0] ef);
        @(negedge clk);
        check(phase, "pin_out", pout, eo);
        check(phase, "pin_oe", poe, ee);
        check(phase, "cmp_flag", flag, ef);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        phase = "R1";
        pins(8'h00, 8'h00, 8'h00);
        rd(5'h00, 8'h00);

        phase = "R2";
        wr(5'h00, 8'h5A); rd(5'h00, 8'h5A);
        wr(5'h00, 8'h00); rd(5'h00, 8'h00);

        phase = "R12";
        wr(5'h02, 8'h3C); rd(5'h02, 8'h3C);
        wr(5'h03, 8'hA5); rd(5'h03, 8'hA5);
        wr(5'h05, 8'hF0); rd(5'h05, 8'hF0);
        wr(5'h06, 8'hE5); rd(5'h06, 8'hE5);
        wr(5'h07, 8'h00); rd(5'h07, 8'h00);
        wr(5'h10, 8'h00); wr(5'h11, 8'h01);
        rd(5'h11, 8'h01); rd(5'h10, 8'h00);

        phase = "R9";
        wr(5'h04, 8'h96); idle();
        pins(8'h96, 8'hF0, 8'h00);
        rd(5'h04, 8'h93);

        phase = "R3";
        wr(5'h00, 8'h01); idle();
        cnt = 16'h0100;
        idle();
        pins(8'h97, 8'hF1, 8'h01);

        phase = "R8";
        rd(5'h05, 8'hF0);

        phase = "R4";
        wr(5'h01, 8'h01); idle();
        pins(8'h96, 8'hF1, 8'h00);

        phase = "R5";
        rd(5'h01, 8'h00);

        phase = "R11";
        wr(5'h01, 8'h08); idle();
        pins(8'h96, 8'hF1, 8'h00);

        phase = "R6";
        wr(5'h00, 8'hBD); idle();
        pins(8'h82, 8'hFD, 8'h00);
        wr(5'h01, 8'h80); idle();
        pins(8'hA6, 8'hFD, 8'h00);

        phase = "R7";
        wr(5'h01, 8'h8D); idle();
        pins(8'hA7, 8'hFD, 8'h00);

        phase = "R10";
        wr(5'h04, 8'h92); idle();
        pins(8'hA7, 8'hFD, 8'h00);
        wr(5'h00, 8'h00); idle();
        pins(8'h92, 8'hF0, 8'h00);

        idle(); idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule